// File: doc/BRIEF.md
# Serial-Access User Flash Emulator

This block models a small non-volatile user store of 512 words of 16 bits in ordinary registers. It is reached through two serial ports. The address port has its own strobe, shift enable and serial input and holds a 9-bit word pointer. The data port has its own strobe, shift enable, serial input and serial output and holds a 16-bit staging word. Both strobes are sampled on the system clock, and the block acts on their rising edges.

Reading works like this. A data strobe with shift enable low copies the word at the pointer into the staging word and advances the pointer, so back-to-back reads walk through the store. Shift strobes then move the word out, most significant bit first. Writing is a program operation: a rising edge on the program request ANDs the staging word into the word at the pointer. Erase is a separate request that fills one half of the store with ones. Both operations raise a busy flag for a fixed, parameterised number of cycles and commit when that time ends.

A three-state controller sequences the operations. Its states are IDLE, PROGRAM and ERASE. The transitions are:
- IDLE→PROGRAM on a program rising edge.
- IDLE→ERASE on an erase rising edge with no program rising edge in the same cycle.
- PROGRAM→IDLE when the program countdown reaches zero, which commits the write.
- ERASE→IDLE when the erase countdown reaches zero, which commits the sector fill.

Top module: `ufm_emu`

## Requirements
- R1: After reset, busy is 0, the serial output is 0, the pointer is 0x000 and every word reads 0xFFFF.
- R2: A rising address strobe with address shift high and busy low shifts the pointer left by one and enters the serial address input at bit 0. Nine strobes load a full 9-bit address, most significant bit first.
- R3: A rising data strobe with data shift high shifts the staging word left and enters the serial data input at bit 0. The serial output always shows bit 15 of the staging word.
- R4: A rising data strobe with data shift low and busy low copies the word at the pointer into the staging word. The pointer then advances by one, and 0x1FF wraps to 0x000.
- R5: A program rising edge in IDLE raises busy on the next cycle. Busy then stays high for exactly PROG_CYCLES cycles.
- R6: When busy falls after a program, the word at the pointer captured at the start becomes the old word AND the staging word. Bits can only be cleared.
- R7: An erase rising edge in IDLE holds busy for exactly ERASE_CYCLES cycles. At the end, every word of the sector chosen by pointer bit 8 at the start is 0xFFFF. Bit 8 = 0 selects 0x000–0x0FF and bit 8 = 1 selects 0x100–0x1FF. The other sector is unchanged.
- R8: If program and erase rise in the same IDLE cycle, only the program is performed.
- R9: While busy is high, program and erase edges, address shifts and parallel loads are ignored. The pointer and staging word are not changed by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_clk | input | 1 | Address strobe, acts on rising edge |
| addr_shift | input | 1 | Address shift enable |
| addr_din | input | 1 | Serial address input |
| data_clk | input | 1 | Data strobe, acts on rising edge |
| data_shift | input | 1 | 1: shift staging word, 0: parallel load from store |
| data_din | input | 1 | Serial data input |
| data_dout | output | 1 | Serial data output (staging bit 15) |
| prog | input | 1 | Program request, acts on rising edge |
| erase | input | 1 | Sector erase request, acts on rising edge |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with PROG_CYCLES = 16 and ERASE_CYCLES = 24. With these values the exact busy lengths can be counted cycle by cycle. The windows are also long enough that, inside one program operation, the bench can issue an erase edge, two address shifts and a parallel load, and then show that none of them took effect. The store keeps its full default depth, so both sector boundaries and the wrap of the pointer from 0x1FF to 0x000 are within reach.

// File: rtl/ufm_emu_pkg.sv
package ufm_emu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } op_state_t;
endpackage

// File: rtl/ufm_addr_reg.sv
module ufm_addr_reg #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              shift_en,
    input  logic              sdin,
    input  logic              busy,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    logic sclk_q;
    logic sedge;

    assign sedge = sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            addr   <= '0;
        end else begin
            sclk_q <= sclk;
            if (!busy) begin
                if (sedge && shift_en)
                    addr <= {addr[ADDR_W-2:0], sdin};
                else if (inc)
                    addr <= addr + 1'b1;
            end
        end
    end

    // R9: pointer frozen while an operation runs
    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr));
    // R4: parallel load advances pointer (wraps)
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !busy && !(sedge && shift_en)) |=> addr == ADDR_W'($past(addr) + 1));
endmodule

// File: rtl/ufm_data_reg.sv
module ufm_data_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              shift_en,
    input  logic              sdin,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic              load_req,
    output logic [DATA_W-1:0] dreg,
    output logic              sdout
);
    logic sclk_q;
    logic sedge;

    assign sedge    = sclk & ~sclk_q;
    assign load_req = sedge & ~shift_en & ~busy;
    assign sdout    = dreg[DATA_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            dreg   <= '0;
        end else begin
            sclk_q <= sclk;
            if (sedge && shift_en)
                dreg <= {dreg[DATA_W-2:0], sdin};
            else if (load_req)
                dreg <= rd_word;
        end
    end

    // R3: serial output moves to the next bit after a shift
    assert_shift_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sedge && shift_en) |=> sdout == $past(dreg[DATA_W-2]));
    // R4: parallel load captures the addressed word
    assert_load_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> dreg == $past(rd_word));
endmodule

// File: rtl/ufm_ctrl.sv
module ufm_ctrl
    import ufm_emu_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic [ADDR_W-1:0] op_addr
);
    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    op_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             prog_q, erase_q;
    logic             prog_rise, erase_rise;

    assign prog_rise  = prog & ~prog_q;
    assign erase_rise = erase & ~erase_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (prog_rise) state_nx = ST_PROG;
                      else if (erase_rise) state_nx = ST_ERASE;
            ST_PROG:  if (cnt == '0) state_nx = ST_IDLE;
            ST_ERASE: if (cnt == '0) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            prog_q  <= 1'b0;
            erase_q <= 1'b0;
            op_addr <= '0;
        end else begin
            prog_q  <= prog;
            erase_q <= erase;
            state   <= state_nx;
            if (state == ST_IDLE && state_nx == ST_PROG) begin
                cnt     <= CNT_W'(PROG_CYCLES - 1);
                op_addr <= addr;
            end else if (state == ST_IDLE && state_nx == ST_ERASE) begin
                cnt     <= CNT_W'(ERASE_CYCLES - 1);
                op_addr <= addr;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        busy         = (state != ST_IDLE);
        commit_prog  = (state == ST_PROG)  && (cnt == '0);
        commit_erase = (state == ST_ERASE) && (cnt == '0);
    end

    // R5: program edge in idle raises busy next cycle
    assert_prog_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prog_rise) |=> busy);
    // R8: simultaneous requests select program
    assert_prog_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prog_rise && erase_rise) |=> state == ST_PROG);
    // R7: lone erase edge enters erase
    assert_erase_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && erase_rise && !prog_rise) |=> state == ST_ERASE);
    // R9: a running operation is not restarted or switched
    assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && cnt != '0) |=> (state == ST_PROG && $stable(op_addr)));
    // R6: commits are mutually exclusive and end busy
    assert_commit_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_prog || commit_erase) |=> !busy);
endmodule

// File: rtl/ufm_emu.sv
module ufm_emu #(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_clk,
    input  logic addr_shift,
    input  logic addr_din,
    input  logic data_clk,
    input  logic data_shift,
    input  logic data_din,
    output logic data_dout,
    input  logic prog,
    input  logic erase,
    output logic busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;

    logic [ADDR_W-1:0] addr, op_addr;
    logic [DATA_W-1:0] dreg, rd_word;
    logic              load_req, commit_prog, commit_erase;
    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_word = mem[addr];

    ufm_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .sclk(addr_clk), .shift_en(addr_shift),
        .sdin(addr_din), .busy(busy), .inc(load_req), .addr(addr)
    );

    ufm_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .sclk(data_clk), .shift_en(data_shift),
        .sdin(data_din), .busy(busy), .rd_word(rd_word), .load_req(load_req),
        .dreg(dreg), .sdout(data_dout)
    );

    ufm_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES),
               .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .prog(prog), .erase(erase), .addr(addr),
        .busy(busy), .commit_prog(commit_prog), .commit_erase(commit_erase),
        .op_addr(op_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit_prog) begin
            mem[op_addr] <= mem[op_addr] & dreg;
        end else if (commit_erase) begin
            for (int i = 0; i < DEPTH; i++)
                if ((i / HALF) == int'(op_addr[ADDR_W-1])) mem[i] <= '1;
        end
    end

    // R6: a program never sets a bit
    assert_prog_clears_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_prog |=> (mem[$past(op_addr)] & ~$past(mem[op_addr])) == '0);
endmodule

// File: tb/tb_ufm_emu.sv
module tb_ufm_emu;
    localparam int PC = 16;
    localparam int EC = 24;

    logic clk = 0, rst_n = 0;
    logic addr_clk = 0, addr_shift = 0, addr_din = 0;
    logic data_clk = 0, data_shift = 0, data_din = 0;
    logic prog = 0, erase = 0;
    logic data_dout, busy;
    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;

    ufm_emu #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
        .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .addr_shift(addr_shift),
        .addr_din(addr_din), .data_clk(data_clk), .data_shift(data_shift),
        .data_din(data_din), .data_dout(data_dout), .prog(prog), .erase(erase),
        .busy(busy)
    );

    // {addr, program data, expected readback}
    localparam logic [40:0] VEC [6] = '{
        {9'h000, 16'h1234, 16'h1234},
        {9'h0FF, 16'hA5A5, 16'hA5A5},
        {9'h100, 16'h0F0F, 16'h0F0F},
        {9'h1FF, 16'hFFFE, 16'hFFFE},
        {9'h000, 16'hFF00, 16'h1200},
        {9'h100, 16'h00FF, 16'h000F}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic pulse_a();
        @(negedge clk) addr_clk = 1;
        @(negedge clk);
        @(negedge clk) addr_clk = 0;
        @(negedge clk);
    endtask

    task automatic pulse_d();
        @(negedge clk) data_clk = 1;
        @(negedge clk);
        @(negedge clk) data_clk = 0;
        @(negedge clk);
    endtask

    task automatic load_addr(logic [8:0] a);
        addr_shift = 1;
        for (int i = 8; i >= 0; i--) begin
            addr_din = a[i];
            pulse_a();
        end
        addr_shift = 0;
    endtask

    task automatic shift_word(logic [15:0] v);
        data_shift = 1;
        for (int i = 15; i >= 0; i--) begin
            data_din = v[i];
            pulse_d();
        end
        data_shift = 0;
    endtask

    task automatic read_word(output logic [15:0] v);
        data_shift = 0;
        pulse_d();
        v[15] = data_dout;
        data_shift = 1;
        data_din = 0;
        for (int i = 14; i >= 0; i--) begin
            pulse_d();
            v[i] = data_dout;
        end
        data_shift = 0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_prog(logic [8:0] a, logic [15:0] d, output int n);
        load_addr(a);
        shift_word(d);
        chk("R3 dout after shift-in", 32'(data_dout), 32'(d[15]));
        @(negedge clk) prog = 1;
        @(negedge clk);
        wait_busy(n);
        prog = 0;
    endtask

    task automatic do_erase(logic [8:0] a, output int n);
        load_addr(a);
        @(negedge clk) erase = 1;
        @(negedge clk);
        wait_busy(n);
        erase = 0;
    endtask

    task automatic read_at(string req, logic [8:0] a, logic [15:0] exp);
        logic [15:0] v;
        load_addr(a);
        read_word(v);
        chk(req, 32'(v), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        int n;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 dout after reset", 32'(data_dout), 32'd0);
        read_word(v);
        chk("R1 word 0 after reset", 32'(v), 32'hFFFF);
        read_at("R1 R2 word 0x055 after reset", 9'h055, 16'hFFFF);

        // R5 R6 table of program/readback vectors
        for (int k = 0; k < 6; k++) begin
            do_prog(VEC[k][40:32], VEC[k][31:16], n);
            chk("R5 program busy length", 32'(n), 32'(PC));
            read_at("R6 R2 program readback", VEC[k][40:32], VEC[k][15:0]);
        end

        // R4 auto-increment and wrap
        load_addr(9'h0FE);
        read_word(v); chk("R4 read 0x0FE", 32'(v), 32'hFFFF);
        read_word(v); chk("R4 autoinc to 0x0FF", 32'(v), 32'hA5A5);
        load_addr(9'h1FF);
        read_word(v); chk("R4 read 0x1FF", 32'(v), 32'hFFFE);
        read_word(v); chk("R4 wrap to 0x000", 32'(v), 32'h1200);

        // R7 erase sector 0
        do_erase(9'h0AB, n);
        chk("R7 erase busy length", 32'(n), 32'(EC));
        read_at("R7 sector0 low erased", 9'h000, 16'hFFFF);
        read_at("R7 sector0 top erased", 9'h0FF, 16'hFFFF);
        read_at("R7 sector1 kept", 9'h100, 16'h000F);

        // R9 requests ignored while busy
        load_addr(9'h020);
        shift_word(16'h00FF);
        @(negedge clk) prog = 1;
        @(negedge clk);
        chk("R9 busy raised", 32'(busy), 32'd1);
        erase = 1;
        addr_shift = 1;
        addr_din = 1;
        pulse_a();
        pulse_a();
        addr_shift = 0;
        data_shift = 0;
        pulse_d();
        chk("R9 still busy during ignored stimulus", 32'(busy), 32'd1);
        wait_busy(n);
        prog = 0;
        erase = 0;
        @(negedge clk);
        read_word(v);
        chk("R9 pointer, staging and erase unaffected", 32'(v), 32'h00FF);

        // R8 simultaneous program and erase
        load_addr(9'h130);
        shift_word(16'h3C3C);
        @(negedge clk) begin prog = 1; erase = 1; end
        @(negedge clk);
        wait_busy(n);
        prog = 0;
        erase = 0;
        chk("R8 program length used", 32'(n), 32'(PC));
        read_at("R8 word programmed", 9'h130, 16'h3C3C);
        read_at("R8 sector1 not erased", 9'h100, 16'h000F);

        // R7 erase sector 1
        do_erase(9'h1FF, n);
        read_at("R7 sector1 erased", 9'h100, 16'hFFFF);
        read_at("R7 sector1 word 0x130 erased", 9'h130, 16'hFFFF);
        read_at("R7 sector0 kept", 9'h020, 16'h00FF);

        summary();
    end
endmodule